// File: doc/BRIEF.md
# Single-Pin Motor Bridge Controller

This block is the digital control core of a single-coil brushless vibration-motor driver. One control input carries three kinds of command. The block tells them apart only by how long the input stays low. While the input is high, the block drives a full H-bridge in the direction given by the sensed magnetic field. Short low phases, such as those of a speed PWM waveform, switch the bridge off only for as long as they last. A low phase that lasts longer than the prebrake limit starts an active brake. After the brake, the block enters sleep, and it stays there until the input goes high again.

The field arrives as a signed digital code and passes through an operate/release hysteresis. An over-temperature code switches the bridge off, and the bridge comes back only after the temperature has fallen by a set margin. When the driven motor produces no field reversal within a timeout, the block reverses the drive for a fixed kick interval so that the rotor can break free. Every change between two different gate patterns passes through a programmable all-off gap. All time spans are counted in clock cycles and are set by parameters.

Top module: `mbc_bridge_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all four gate enables are low and `sleep_o` is high.
- R2: In the running mode with the control input high, a field code at or above `OP_LEVEL` drives `hs1_en` and `ls2_en` (pattern {hs1,ls1,hs2,ls2} = 1001). A code at or below `RP_LEVEL` drives `hs2_en` and `ls1_en` (pattern 0110).
- R3: A field code strictly between `RP_LEVEL` and `OP_LEVEL` leaves the drive direction unchanged.
- R4: The control input passes a two-flop synchroniser. A low phase shorter than `PREBRAKE_CYC` cycles switches the gates off and then back on. It never starts the brake and never asserts `sleep_o`.
- R5: After the synchronised control input has been low for `PREBRAKE_CYC` consecutive cycles in the running mode, the block brakes. For exactly `BRAKE_CYC` cycles the pattern is 0101: both low-side enables on, both high-side enables off.
- R6: After the brake, the block sleeps: `sleep_o` high, all gates off. It stays asleep for as long as the control input stays low, and it returns to the running mode once the input is high.
- R7: A control input held high never causes braking or sleep.
- R8: A temperature code at or above `TRIP_LEVEL` turns all gates off from the second clock edge on. They stay off until the code is at or below `TRIP_LEVEL - HYST_LEVEL`.
- R9: In the running mode, `STALL_CYC` cycles without a change of the latched field polarity start a kick. For `KICK_CYC` cycles the commanded direction is the reverse of the latched one.
- R10: A change from one non-zero gate pattern to a different non-zero pattern is preceded by at least `DEAD_CYC + 1` all-off cycles. No leg ever has its high-side and low-side enables on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_in | input | 1 | Multifunction control level (asynchronous) |
| field_in | input | FIELD_W | Signed magnetic field code |
| temp_in | input | TEMP_W | Junction temperature code, 1 LSB per degree |
| hs1_en | output | 1 | High-side gate enable, output 1 |
| ls1_en | output | 1 | Low-side gate enable, output 1 |
| hs2_en | output | 1 | High-side gate enable, output 2 |
| ls2_en | output | 1 | Low-side gate enable, output 2 |
| sleep_o | output | 1 | High while the block sleeps |

## Verification
The assertions check the following on every cycle:
- no leg ever conducts high and low together;
- no gate pattern changes directly into a different non-zero one;
- the gates are off one cycle after the hot flag is raised, and they are off in settled sleep;
- a sleeping block stays asleep while the control level is low;
- a field code inside the hysteresis band leaves the polarity unchanged;
- the hot flag clears only at or below the release code.

Only the bench scenarios can show the following:
- the exact brake length;
- that PWM low phases never reach the brake;
- that a stalled rotor gets a reversal of the drive;
- that the block wakes with the correct direction.

The bench shows these by comparing against a behavioural model on every clock.

// File: rtl/mbc_pkg.sv
// Package: shared types and gate encoding for the single-pin bridge controller.
// Assumes the gate vector is ordered {hs1, ls1, hs2, ls2}.
package mbc_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_BRAKE = 2'd1,
        MODE_SLEEP = 2'd2
    } mode_e;

    localparam int GATE_W = 4;
    localparam int G_HS1  = 3;
    localparam int G_LS1  = 2;
    localparam int G_HS2  = 1;
    localparam int G_LS2  = 0;

    // Maps the requested action to a gate pattern; drive wins over brake.
    function automatic logic [GATE_W-1:0] gate_pattern(input logic drive,
                                                       input logic brake,
                                                       input logic dir);
        logic [GATE_W-1:0] g;
        g = '0;
        if (drive) begin
            if (dir) begin
                g[G_HS1] = 1'b1;
                g[G_LS2] = 1'b1;
            end else begin
                g[G_HS2] = 1'b1;
                g[G_LS1] = 1'b1;
            end
        end else if (brake) begin
            g[G_LS1] = 1'b1;
            g[G_LS2] = 1'b1;
        end
        return g;
    endfunction

endpackage

// File: rtl/mbc_input_decode.sv
// Module: synchronises the control level and measures how long it stays low.
// Assumes ctl_in is asynchronous. The low-time count saturates at PREBRAKE_CYC
// and clears whenever the synchronised level is high.
module mbc_input_decode #(
    parameter int PREBRAKE_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_in,
    output logic ctl_lvl,
    output logic low_long
);
    localparam int LW = $clog2(PREBRAKE_CYC + 1);

    logic             sync_a;
    logic             sync_b;
    logic [LW-1:0]    low_cnt;

    // Two-flop synchroniser for the control level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= ctl_in;
            sync_b <= sync_a;
        end
    end

    // Saturating low-duration counter, cleared by a high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (sync_b) begin
            low_cnt <= '0;
        end else if (low_cnt != LW'(PREBRAKE_CYC)) begin
            low_cnt <= low_cnt + LW'(1);
        end
    end

    assign ctl_lvl  = sync_b;
    assign low_long = (low_cnt == LW'(PREBRAKE_CYC));

    // R4: a high level always clears the long-low indication by the next cycle.
    assert_high_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_lvl |=> !low_long);

endmodule

// File: rtl/mbc_hall_latch.sv
// Module: turns the signed field code into a latched polarity with hysteresis
// and flags each polarity change. Assumes RP_LEVEL < OP_LEVEL.
module mbc_hall_latch #(
    parameter int FIELD_W  = 8,
    parameter int OP_LEVEL = 35,
    parameter int RP_LEVEL = -35
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic signed [FIELD_W-1:0] field_in,
    output logic                      pol,
    output logic                      hall_edge
);
    localparam logic signed [FIELD_W-1:0] OP_CODE = FIELD_W'(OP_LEVEL);
    localparam logic signed [FIELD_W-1:0] RP_CODE = FIELD_W'(RP_LEVEL);

    logic pol_prev;
    logic in_band;

    assign in_band = (field_in > RP_CODE) && (field_in < OP_CODE);

    // Hysteretic polarity latch plus a one-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol      <= 1'b0;
            pol_prev <= 1'b0;
        end else begin
            pol_prev <= pol;
            if (field_in >= OP_CODE) begin
                pol <= 1'b1;
            end else if (field_in <= RP_CODE) begin
                pol <= 1'b0;
            end
        end
    end

    assign hall_edge = (pol != pol_prev);

    // R3: a field inside the hysteresis band holds the latched polarity.
    assert_band_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_band |=> $stable(pol));

endmodule

// File: rtl/mbc_thermal_guard.sv
// Module: over-temperature flag with a trip level and a release margin.
// Assumes one code LSB per degree and HYST_LEVEL below TRIP_LEVEL.
module mbc_thermal_guard #(
    parameter int TEMP_W     = 8,
    parameter int TRIP_LEVEL = 165,
    parameter int HYST_LEVEL = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_in,
    output logic              hot
);
    localparam logic [TEMP_W-1:0] TRIP_CODE  = TEMP_W'(TRIP_LEVEL);
    localparam logic [TEMP_W-1:0] CLEAR_CODE = TEMP_W'(TRIP_LEVEL - HYST_LEVEL);

    // Set at the trip code, cleared only at or below the release code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot <= 1'b0;
        end else if (temp_in >= TRIP_CODE) begin
            hot <= 1'b1;
        end else if (temp_in <= CLEAR_CODE) begin
            hot <= 1'b0;
        end
    end

    // R8: the flag drops only after the temperature reached the release code.
    assert_release_margin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hot) && !hot) |-> ($past(temp_in) <= CLEAR_CODE));

endmodule

// File: rtl/mbc_gate_sequencer.sv
// Module: applies the requested gate pattern and inserts an all-off gap.
// A pattern turns off at once. A new pattern loads only after DEAD_CYC
// further cycles with all gates off.
module mbc_gate_sequencer import mbc_pkg::*; #(
    parameter int DEAD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GATE_W-1:0] want,
    output logic [GATE_W-1:0] gates
);
    localparam int DW = $clog2(DEAD_CYC + 2);

    logic [DW-1:0] dead_cnt;

    // Gate register with the dead-time countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gates    <= '0;
            dead_cnt <= '0;
        end else if (gates != '0 && gates != want) begin
            gates    <= '0;
            dead_cnt <= DW'(DEAD_CYC);
        end else if (gates == '0 && dead_cnt != '0) begin
            dead_cnt <= dead_cnt - DW'(1);
        end else if (gates == '0) begin
            gates <= want;
        end
    end

    // R10: no leg ever conducts high side and low side together.
    assert_leg_safe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates[G_HS1] && gates[G_LS1]) && !(gates[G_HS2] && gates[G_LS2]));

    // R10: a non-zero pattern never turns directly into a different one.
    assert_dead_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gates) != '0 && gates != '0) |-> (gates == $past(gates)));

endmodule

// File: rtl/mbc_bridge_ctrl.sv
// Module: top of the single-pin bridge controller. Holds the run/brake/sleep
// mode, the stall watchdog and kick, and forms the gate request. Assumes
// BRAKE_CYC >= 1, STALL_CYC >= 2 and KICK_CYC >= 1. All times are in clocks.
module mbc_bridge_ctrl import mbc_pkg::*; #(
    parameter int FIELD_W      = 8,
    parameter int TEMP_W       = 8,
    parameter int OP_LEVEL     = 35,
    parameter int RP_LEVEL     = -35,
    parameter int TRIP_LEVEL   = 165,
    parameter int HYST_LEVEL   = 20,
    parameter int PREBRAKE_CYC = 250000,
    parameter int BRAKE_CYC    = 1000000,
    parameter int STALL_CYC    = 20000000,
    parameter int KICK_CYC     = 500000,
    parameter int DEAD_CYC     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_in,
    input  logic signed [FIELD_W-1:0] field_in,
    input  logic [TEMP_W-1:0]         temp_in,
    output logic                      hs1_en,
    output logic                      ls1_en,
    output logic                      hs2_en,
    output logic                      ls2_en,
    output logic                      sleep_o
);
    localparam int BW  = $clog2(BRAKE_CYC + 1);
    localparam int STW = $clog2(STALL_CYC + 1);
    localparam int KW  = $clog2(KICK_CYC + 1);

    logic              ctl_lvl;
    logic              low_long;
    logic              pol;
    logic              hall_edge;
    logic              hot;
    logic [GATE_W-1:0] want;
    logic [GATE_W-1:0] gates;
    mode_e             mode;
    logic [BW-1:0]     brk_cnt;
    logic [STW-1:0]    stall_cnt;
    logic [KW-1:0]     kick_cnt;
    logic              drive_on;
    logic              brake_on;
    logic              dir;

    mbc_input_decode #(.PREBRAKE_CYC(PREBRAKE_CYC)) u_decode (
        .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in),
        .ctl_lvl(ctl_lvl), .low_long(low_long)
    );

    mbc_hall_latch #(.FIELD_W(FIELD_W), .OP_LEVEL(OP_LEVEL), .RP_LEVEL(RP_LEVEL)) u_hall (
        .clk(clk), .rst_n(rst_n), .field_in(field_in),
        .pol(pol), .hall_edge(hall_edge)
    );

    mbc_thermal_guard #(.TEMP_W(TEMP_W), .TRIP_LEVEL(TRIP_LEVEL), .HYST_LEVEL(HYST_LEVEL)) u_thermal (
        .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .hot(hot)
    );

    // Mode sequence: run -> brake (timed) -> sleep -> run on a high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_SLEEP;
            brk_cnt <= '0;
        end else begin
            case (mode)
                MODE_RUN: begin
                    if (low_long) begin
                        mode    <= MODE_BRAKE;
                        brk_cnt <= '0;
                    end
                end
                MODE_BRAKE: begin
                    if (brk_cnt == BW'(BRAKE_CYC - 1)) begin
                        mode <= MODE_SLEEP;
                    end else begin
                        brk_cnt <= brk_cnt + BW'(1);
                    end
                end
                MODE_SLEEP: begin
                    if (ctl_lvl) begin
                        mode <= MODE_RUN;
                    end
                end
                default: mode <= MODE_SLEEP;
            endcase
        end
    end

    // Stall watchdog and reverse-drive kick, active only while running cool.
    always_ff @(posedge clk) begin
        if (!rst_n || mode != MODE_RUN || hot) begin
            stall_cnt <= '0;
            kick_cnt  <= '0;
        end else if (kick_cnt != '0) begin
            kick_cnt  <= kick_cnt - KW'(1);
            stall_cnt <= '0;
        end else if (hall_edge) begin
            stall_cnt <= '0;
        end else if (stall_cnt == STW'(STALL_CYC - 1)) begin
            stall_cnt <= '0;
            kick_cnt  <= KW'(KICK_CYC);
        end else begin
            stall_cnt <= stall_cnt + STW'(1);
        end
    end

    // Gate request from mode, control level, temperature and direction.
    always_comb begin
        drive_on = (mode == MODE_RUN) && ctl_lvl && !hot;
        brake_on = (mode == MODE_BRAKE) && !hot;
        dir      = pol ^ (kick_cnt != '0);
        want     = gate_pattern(drive_on, brake_on, dir);
    end

    mbc_gate_sequencer #(.DEAD_CYC(DEAD_CYC)) u_gates (
        .clk(clk), .rst_n(rst_n), .want(want), .gates(gates)
    );

    assign hs1_en  = gates[G_HS1];
    assign ls1_en  = gates[G_LS1];
    assign hs2_en  = gates[G_HS2];
    assign ls2_en  = gates[G_LS2];
    assign sleep_o = (mode == MODE_SLEEP);

    // R8: a raised hot flag has all gates off one cycle later.
    assert_hot_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> (gates == '0));

    // R6: settled sleep keeps every gate off.
    assert_sleep_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP && $past(mode) == MODE_SLEEP) |-> (gates == '0));

    // R6: sleep is left only when the control level is high.
    assert_stay_asleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP && !ctl_lvl) |=> (mode == MODE_SLEEP));

endmodule

// File: tb/mbc_bridge_ctrl_tb.sv
// Bench: drives scenarios and compares the design against a behavioural model
// on every clock, plus scenario checks tagged by requirement.
module mbc_bridge_ctrl_tb;
    localparam int PRE   = 20;
    localparam int BRK   = 16;
    localparam int STALL = 200;
    localparam int KICK  = 10;
    localparam int DEAD  = 2;
    localparam int TRIP  = 165;
    localparam int HYST  = 20;
    localparam int OPL   = 35;
    localparam int RPL   = -35;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_in = 1'b0;
    logic signed [7:0] field_in = 8'sd0;
    logic [7:0]        temp_in = 8'd25;
    logic hs1_en, ls1_en, hs2_en, ls2_en, sleep_o;

    int    errors = 0;
    int    checks = 0;
    bit    armed = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    mbc_bridge_ctrl #(
        .FIELD_W(8), .TEMP_W(8), .OP_LEVEL(OPL), .RP_LEVEL(RPL),
        .TRIP_LEVEL(TRIP), .HYST_LEVEL(HYST), .PREBRAKE_CYC(PRE),
        .BRAKE_CYC(BRK), .STALL_CYC(STALL), .KICK_CYC(KICK), .DEAD_CYC(DEAD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_in(ctl_in), .field_in(field_in),
        .temp_in(temp_in), .hs1_en(hs1_en), .ls1_en(ls1_en),
        .hs2_en(hs2_en), .ls2_en(ls2_en), .sleep_o(sleep_o)
    );

    logic [3:0] g_act;
    assign g_act = {hs1_en, ls1_en, hs2_en, ls2_en};

    // Behavioural model state (mode: 0 run, 1 brake, 2 sleep).
    int m_s1 = 0, m_s2 = 0, m_low = 0, m_pol = 0, m_polp = 0, m_hot = 0;
    int m_mode = 2, m_brk = 0, m_stall = 0, m_kick = 0, m_gate = 0, m_dead = 0;

    always @(posedge clk) begin
        int want, n_gate, n_dead, n_stall, n_kick, n_mode, n_brk, n_low, n_pol, n_hot;
        bit drive, brk_on, dir, hedge;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_low = 0; m_pol = 0; m_polp = 0; m_hot = 0;
            m_mode = 2; m_brk = 0; m_stall = 0; m_kick = 0; m_gate = 0; m_dead = 0;
        end else begin
            drive  = (m_mode == 0) && (m_s2 == 1) && (m_hot == 0);
            brk_on = (m_mode == 1) && (m_hot == 0);
            dir    = (m_pol != 0) ^ (m_kick != 0);
            if (drive) want = dir ? 9 : 6;
            else if (brk_on) want = 5;
            else want = 0;
            hedge = (m_pol != m_polp);
            n_gate = m_gate; n_dead = m_dead;
            if (m_gate != 0 && m_gate != want) begin n_gate = 0; n_dead = DEAD; end
            else if (m_gate == 0 && m_dead != 0) n_dead = m_dead - 1;
            else if (m_gate == 0) n_gate = want;
            n_stall = 0; n_kick = 0;
            if (m_mode != 0 || m_hot != 0) begin n_stall = 0; n_kick = 0; end
            else if (m_kick != 0) n_kick = m_kick - 1;
            else if (hedge) n_stall = 0;
            else if (m_stall == STALL - 1) n_kick = KICK;
            else n_stall = m_stall + 1;
            n_mode = m_mode; n_brk = m_brk;
            if (m_mode == 0) begin
                if (m_low == PRE) begin n_mode = 1; n_brk = 0; end
            end else if (m_mode == 1) begin
                if (m_brk == BRK - 1) n_mode = 2; else n_brk = m_brk + 1;
            end else if (m_s2 == 1) n_mode = 0;
            n_low = (m_s2 == 1) ? 0 : ((m_low < PRE) ? m_low + 1 : m_low);
            n_pol = (int'(field_in) >= OPL) ? 1 : ((int'(field_in) <= RPL) ? 0 : m_pol);
            n_hot = (int'(temp_in) >= TRIP) ? 1 : ((int'(temp_in) <= TRIP - HYST) ? 0 : m_hot);
            m_polp = m_pol; m_pol = n_pol; m_hot = n_hot; m_low = n_low;
            m_mode = n_mode; m_brk = n_brk; m_stall = n_stall; m_kick = n_kick;
            m_gate = n_gate; m_dead = n_dead;
            m_s2 = m_s1; m_s1 = int'(ctl_in);
        end
    end

    // Per-cycle comparison and dead-gap monitor (R10).
    int last_nz = 0;
    int zrun = 0;
    always @(negedge clk) begin
        if (armed) begin
            checks++;
            if (int'(g_act) != m_gate || int'(sleep_o) != (m_mode == 2 ? 1 : 0)) begin
                errors++;
                $display("FAIL %s per-cycle gates=%b sleep=%b expected gates=%b sleep=%0d",
                         cur_req, g_act, sleep_o, 4'(m_gate), (m_mode == 2));
            end
            if (g_act != 4'b0) begin
                if (last_nz != 0 && int'(g_act) != last_nz) begin
                    checks++;
                    if (zrun < DEAD + 1) begin
                        errors++;
                        $display("FAIL R10 all-off gap actual=%0d expected>=%0d", zrun, DEAD + 1);
                    end
                end
                last_nz = int'(g_act);
                zrun = 0;
            end else zrun++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int brake_seen, sleep_seen, on_seen, off_seen, rev_seen;
        cyc(5);
        chk("R1", int'(g_act), 0, "gates in reset");
        chk("R1", int'(sleep_o), 1, "sleep in reset");
        rst_n = 1'b1;
        armed = 1'b1;
        cyc(1);
        chk("R1", int'(g_act), 0, "gates after reset");
        chk("R1", int'(sleep_o), 1, "sleep after reset");

        cur_req = "R2";
        ctl_in = 1'b1; field_in = 8'sd50;
        cyc(10);
        chk("R2", int'(sleep_o), 0, "woken");
        chk("R2", int'(g_act), 9, "positive field pattern");
        field_in = -8'sd50;
        cyc(10);
        chk("R2", int'(g_act), 6, "negative field pattern");

        cur_req = "R3";
        field_in = 8'sd10;
        cyc(10);
        chk("R3", int'(g_act), 6, "in-band hold after negative");
        field_in = 8'sd50;
        cyc(10);
        field_in = -8'sd10;
        cyc(10);
        chk("R3", int'(g_act), 9, "in-band hold after positive");

        cur_req = "R4";
        brake_seen = 0; sleep_seen = 0; on_seen = 0; off_seen = 0;
        for (int p = 0; p < 10; p++) begin
            ctl_in = 1'b1;
            for (int k = 0; k < 6; k++) begin
                cyc(1);
                if (g_act == 4'b0101) brake_seen++;
                if (sleep_o) sleep_seen++;
                if (g_act == 4'b1001) on_seen++;
                if (g_act == 4'b0) off_seen++;
            end
            ctl_in = 1'b0;
            for (int k = 0; k < 6; k++) begin
                cyc(1);
                if (g_act == 4'b0101) brake_seen++;
                if (sleep_o) sleep_seen++;
                if (g_act == 4'b1001) on_seen++;
                if (g_act == 4'b0) off_seen++;
            end
        end
        ctl_in = 1'b1;
        chk("R4", brake_seen, 0, "brake cycles during PWM");
        chk("R4", sleep_seen, 0, "sleep cycles during PWM");
        chk("R4", (on_seen > 0 && off_seen > 0) ? 1 : 0, 1, "gates follow PWM");

        cur_req = "R7";
        brake_seen = 0; sleep_seen = 0;
        for (int k = 0; k < 250; k++) begin
            if (k % 50 == 0) field_in = ((k / 50) % 2 == 0) ? -8'sd60 : 8'sd60;
            cyc(1);
            if (g_act == 4'b0101) brake_seen++;
            if (sleep_o) sleep_seen++;
        end
        chk("R7", brake_seen + sleep_seen, 0, "brake or sleep with level held high");

        cur_req = "R5";
        field_in = 8'sd50;
        cyc(10);
        ctl_in = 1'b0;
        brake_seen = 0;
        for (int k = 0; k < 60; k++) begin
            cyc(1);
            if (g_act == 4'b0101) brake_seen++;
        end
        chk("R5", brake_seen, BRK, "brake pattern cycles");

        cur_req = "R6";
        chk("R6", int'(sleep_o), 1, "asleep after brake");
        chk("R6", int'(g_act), 0, "gates off asleep");
        cyc(100);
        chk("R6", int'(sleep_o), 1, "still asleep while low");
        ctl_in = 1'b1;
        cyc(10);
        chk("R6", int'(sleep_o), 0, "awake after high");
        chk("R6", int'(g_act), 9, "drive after wake");

        cur_req = "R8";
        temp_in = 8'd170;
        cyc(5);
        chk("R8", int'(g_act), 0, "off when hot");
        temp_in = 8'd150;
        cyc(10);
        chk("R8", int'(g_act), 0, "off inside margin");
        temp_in = 8'd145;
        cyc(10);
        chk("R8", int'(g_act), 9, "back on at release");

        cur_req = "R9";
        rev_seen = 0;
        for (int k = 0; k < 260; k++) begin
            cyc(1);
            if (g_act == 4'b0110) rev_seen++;
        end
        chk("R9", (rev_seen > 0) ? 1 : 0, 1, "reverse drive on stall");
        chk("R9", int'(g_act), 9, "normal drive after kick");

        cur_req = "R10";
        cyc(5);
        armed = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule